// File: doc/BRIEF.md
# Banded Parallel 3x3 Image Filter

The block filters a greyscale frame held in on-chip memory with a 3x3 neighbourhood operator. The frame is cut into horizontal bands of equal height. Each band has its own filter engine, with a private read port into the input frame and a private write port into the output frame, so no common bus is arbitrated. All engines run at the same time.

An engine streams its rows through two line buffers into a 3x3 window register and writes one filtered pixel per fetched column. Each engine also fetches one halo row from the band above and one from the band below. Pixels next to an internal band boundary therefore come out exactly as a single whole-frame pass would produce them. At the outer frame edges, missing neighbours are taken from the nearest valid pixel.

A per-band mode bit selects either a Gaussian smoothing kernel or a box mean, so each band can run a different operator in the same pass. Software loads the frame through a write port, pulses start, waits for done and reads the result back through a read port. The default build is 32x32 pixels in four bands of eight rows. Every dimension is a package parameter.

Top module: `band_filter_top`

## Requirements
- R1: A single accepted start launches every band engine in the same cycle, and together the engines write every pixel of the output frame in one pass.
- R2: With mode bit 0 (mode_i[b] selects band b, and band 0 holds the topmost rows), an output pixel equals (n00+2n01+n02+2n10+4n11+2n12+n20+2n21+n22+8)>>4 over its 3x3 neighbourhood, which rounds half up.
- R3: With mode bit 1, an output pixel equals (sum of the nine neighbours * 57) >> 9.
- R4: The mode bits are captured on the accepted start, and changing mode_i during a pass has no effect on that pass's output.
- R5: Pixels in the first and last row of each band, at internal band boundaries, are bit-identical to whole-frame filtering, using the neighbouring band's rows.
- R6: At the outer frame edges (row 0, the last row, column 0, the last column), a missing neighbour takes the value of the nearest pixel inside the frame.
- R7: Each engine writes exactly BAND_ROWS*IMG_W pixels per pass, and only to addresses inside its own band. Addresses are row*IMG_W+column.
- R8: busy_o is high from the cycle after an accepted start until done_o rises. done_o is a one-cycle pulse no later than (BAND_ROWS+2)*(IMG_W+1)+4 cycles after start.
- R9: A start or a frame load presented while busy_o is high is ignored.
- R10: After reset, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one pixel into the input frame |
| ld_addr | input | ADDR_W | Input frame address, row*IMG_W+column |
| ld_data | input | PIX_W | Pixel to write |
| start_i | input | 1 | Launch a pass (ignored while busy) |
| mode_i | input | BANDS | Per-band operator: 0 Gaussian, 1 box mean |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle pulse at end of pass |
| rd_addr | input | ADDR_W | Output frame read address |
| rd_data | output | PIX_W | Filtered pixel at rd_addr (combinational) |

## Verification
Two functions meet in one cycle at the band seams. In the same clock, an engine fetches a halo row from its neighbour's region while that neighbour reads its own first or last row. Stripe frames whose bright rows sit exactly on band seams provoke this, and every output pixel is judged against a whole-frame reference model written in the bench. A second collision, a start or load arriving mid-pass, is injected while busy. It is judged by checking that the pass ends on schedule with unchanged results and that a rerun reproduces the original frame.

// File: rtl/bandflt_pkg.sv
package bandflt_pkg;
    parameter int PIX_W     = 8;
    parameter int IMG_W     = 32;
    parameter int BANDS     = 4;
    parameter int BAND_ROWS = 8;

    localparam int IMG_H     = BANDS * BAND_ROWS;
    localparam int FRAME_PIX = IMG_H * IMG_W;
    localparam int ADDR_W    = $clog2(FRAME_PIX);
    localparam int ROW_W     = $clog2(IMG_H);
    localparam int COL_W     = $clog2(IMG_W + 1);
    localparam int LB_W      = $clog2(IMG_W);
    localparam int SROW_W    = $clog2(BAND_ROWS + 2);
    localparam int CNT_W     = $clog2(BAND_ROWS * IMG_W + 1);
    localparam int SUM_W     = PIX_W + 5;
    localparam int BOX_MUL   = 57;
    localparam int BOX_SHIFT = 9;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } col3_t;

    typedef enum logic {
        OP_GAUSS = 1'b0,
        OP_BOX   = 1'b1
    } op_e;

    function automatic int clamp_row(input int r);
        if (r < 0)
            return 0;
        if (r > IMG_H - 1)
            return IMG_H - 1;
        return r;
    endfunction
endpackage

// File: rtl/kernel_unit.sv
module kernel_unit
    import bandflt_pkg::*;
(
    input  col3_t left,
    input  col3_t cen,
    input  col3_t right,
    input  op_e   op,
    output pix_t  pix
);
    logic [SUM_W-1:0]  g_sum;
    logic [SUM_W-1:0]  b_sum;
    logic [SUM_W+6:0]  b_prod;
    logic [SUM_W-1:0]  g_rnd;

    always_comb begin
        g_sum = SUM_W'(left.top) + (SUM_W'(cen.top) << 1) + SUM_W'(right.top)
              + (SUM_W'(left.mid) << 1) + (SUM_W'(cen.mid) << 2) + (SUM_W'(right.mid) << 1)
              + SUM_W'(left.bot) + (SUM_W'(cen.bot) << 1) + SUM_W'(right.bot);
        b_sum = SUM_W'(left.top) + SUM_W'(cen.top) + SUM_W'(right.top)
              + SUM_W'(left.mid) + SUM_W'(cen.mid) + SUM_W'(right.mid)
              + SUM_W'(left.bot) + SUM_W'(cen.bot) + SUM_W'(right.bot);
        g_rnd  = (g_sum + SUM_W'(8)) >> 4;
        b_prod = (SUM_W+7)'(b_sum) * (SUM_W+7)'(BOX_MUL);
        if (op == OP_GAUSS)
            pix = PIX_W'(g_rnd);
        else
            pix = PIX_W'(b_prod >> BOX_SHIFT);
    end
endmodule

// File: rtl/band_engine.sv
module band_engine
    import bandflt_pkg::*;
#(
    parameter int BAND_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               op_in,
    output logic [ADDR_W-1:0] rd_addr,
    input  pix_t              rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output pix_t              wr_data,
    output logic              fin
);
    localparam int BASE     = BAND_IDX * BAND_ROWS;
    localparam int LAST_S   = BAND_ROWS + 1;
    localparam int PASS_PIX = BAND_ROWS * IMG_W;
    localparam int LO_ROW   = (BASE > 0) ? BASE - 1 : 0;
    localparam int HI_ROW   = (BASE + BAND_ROWS < IMG_H) ? BASE + BAND_ROWS : IMG_H - 1;

    logic              run_q;
    logic [SROW_W-1:0] s_q;
    logic [COL_W-1:0]  fc_q;
    op_e               op_q;
    pix_t              lb0 [IMG_W];
    pix_t              lb1 [IMG_W];
    col3_t             win_l, win_c, win_r;
    col3_t             new_col;
    logic [LB_W-1:0]   lb_idx;
    logic              out_v, out_last, fin_q;
    logic [ROW_W-1:0]  out_row;
    logic [LB_W-1:0]   out_col;
    logic [CNT_W-1:0]  wr_cnt;
    logic              at_row_end;

    always_comb begin
        int r;
        int c;
        r = clamp_row(BASE + int'(s_q) - 1);
        c = int'(fc_q);
        if (c > IMG_W - 1)
            c = IMG_W - 1;
        rd_addr = ADDR_W'(r * IMG_W + c);
    end

    assign lb_idx     = LB_W'(fc_q);
    assign at_row_end = (fc_q == COL_W'(IMG_W));
    assign new_col    = '{top: lb1[lb_idx], mid: lb0[lb_idx], bot: rd_data};

    always_ff @(posedge clk) begin
        if (run_q && !at_row_end) begin
            lb1[lb_idx] <= lb0[lb_idx];
            lb0[lb_idx] <= rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            s_q      <= '0;
            fc_q     <= '0;
            op_q     <= OP_GAUSS;
            win_l    <= '0;
            win_c    <= '0;
            win_r    <= '0;
            out_v    <= 1'b0;
            out_last <= 1'b0;
            out_row  <= '0;
            out_col  <= '0;
            fin_q    <= 1'b0;
            wr_cnt   <= '0;
        end else begin
            fin_q    <= out_v && out_last;
            out_v    <= run_q && (s_q >= SROW_W'(2)) && (fc_q >= COL_W'(1));
            out_last <= run_q && (s_q == SROW_W'(LAST_S)) && at_row_end;
            out_row  <= ROW_W'(BASE + int'(s_q) - 2);
            out_col  <= LB_W'(int'(fc_q) - 1);
            if (out_v)
                wr_cnt <= wr_cnt + CNT_W'(1);
            if (start && !run_q) begin
                run_q  <= 1'b1;
                s_q    <= '0;
                fc_q   <= '0;
                op_q   <= op_in;
                wr_cnt <= '0;
            end else if (run_q) begin
                if (fc_q == '0) begin
                    win_l <= new_col;
                    win_c <= new_col;
                    win_r <= new_col;
                end else if (!at_row_end) begin
                    win_l <= win_c;
                    win_c <= win_r;
                    win_r <= new_col;
                end else begin
                    win_l <= win_c;
                    win_c <= win_r;
                end
                if (at_row_end) begin
                    fc_q <= '0;
                    if (s_q == SROW_W'(LAST_S))
                        run_q <= 1'b0;
                    else
                        s_q <= s_q + SROW_W'(1);
                end else begin
                    fc_q <= fc_q + COL_W'(1);
                end
            end
        end
    end

    kernel_unit u_kernel (
        .left  (win_l),
        .cen   (win_c),
        .right (win_r),
        .op    (op_q),
        .pix   (wr_data)
    );

    assign wr_en   = out_v;
    assign wr_addr = ADDR_W'(int'(out_row) * IMG_W + int'(out_col));
    assign fin     = fin_q;

    // R7
    wr_in_band_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) >= BASE * IMG_W) && (int'(wr_addr) < (BASE + BAND_ROWS) * IMG_W));

    // R5
    rd_in_halo_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (int'(rd_addr) >= LO_ROW * IMG_W) && (int'(rd_addr) < (HI_ROW + 1) * IMG_W));

    // R7
    pass_count_chk: assert property (@(posedge clk) disable iff (rst)
        fin |-> (int'(wr_cnt) == PASS_PIX));

    // R2
    flat_window_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && win_l == win_c && win_r == win_c
         && win_c.top == win_c.mid && win_c.bot == win_c.mid) |-> (wr_data == win_c.mid));
endmodule

// File: rtl/band_filter_top.sv
module band_filter_top
    import bandflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [PIX_W-1:0]  ld_data,
    input  logic              start_i,
    input  logic [BANDS-1:0]  mode_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  rd_data
);
    pix_t              in_mem  [FRAME_PIX];
    pix_t              out_mem [FRAME_PIX];
    logic [ADDR_W-1:0] e_rd_addr [BANDS];
    pix_t              e_rd_data [BANDS];
    logic              e_wr_en   [BANDS];
    logic [ADDR_W-1:0] e_wr_addr [BANDS];
    pix_t              e_wr_data [BANDS];
    logic [BANDS-1:0]  fin_vec;
    logic [BANDS-1:0]  fin_seen;
    logic              busy_q, done_q, go;

    assign go = start_i && !busy_q;

    for (genvar b = 0; b < BANDS; b++) begin : g_band
        logic fin_b;
        assign e_rd_data[b] = in_mem[e_rd_addr[b]];
        band_engine #(.BAND_IDX(b)) u_eng (
            .clk     (clk),
            .rst     (rst),
            .start   (go),
            .op_in   (op_e'(mode_i[b])),
            .rd_addr (e_rd_addr[b]),
            .rd_data (e_rd_data[b]),
            .wr_en   (e_wr_en[b]),
            .wr_addr (e_wr_addr[b]),
            .wr_data (e_wr_data[b]),
            .fin     (fin_b)
        );
        assign fin_vec[b] = fin_b;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !busy_q)
            in_mem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < BANDS; b++) begin
            if (e_wr_en[b])
                out_mem[e_wr_addr[b]] <= e_wr_data[b];
        end
    end

    assign rd_data = out_mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            fin_seen <= '0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                busy_q   <= 1'b1;
                fin_seen <= '0;
            end else if (busy_q) begin
                fin_seen <= fin_seen | fin_vec;
                if (&(fin_seen | fin_vec)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    busy_until_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(&(fin_seen | fin_vec))) |=> busy_o);

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> !done_o || !busy_o);

    // R1
    fin_together_chk: assert property (@(posedge clk) disable iff (rst)
        (|fin_vec) |-> (&(fin_vec | fin_seen)));
endmodule

// File: tb/band_filter_top_tb.sv
`timescale 1ns/1ps
module band_filter_top_tb_top;
    import bandflt_pkg::*;

    localparam int PASS_LIMIT = (BAND_ROWS + 2) * (IMG_W + 1) + 4;
    localparam int PASS_MIN   = (BAND_ROWS + 2) * (IMG_W + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_en;
    logic [ADDR_W-1:0] ld_addr;
    logic [PIX_W-1:0]  ld_data;
    logic              start_i;
    logic [BANDS-1:0]  mode_i;
    logic              busy_o, done_o;
    logic [ADDR_W-1:0] rd_addr;
    logic [PIX_W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int fr [IMG_H][IMG_W];

    always #2.5 clk = ~clk;

    band_filter_top dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start_i(start_i), .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int px(input int r, input int c);
        int rr = (r < 0) ? 0 : ((r > IMG_H - 1) ? IMG_H - 1 : r);
        int cc = (c < 0) ? 0 : ((c > IMG_W - 1) ? IMG_W - 1 : c);
        return fr[rr][cc];
    endfunction

    function automatic int ref_px(input int r, input int c, input int op);
        int s = 0;
        if (op == 0) begin
            for (int dr = -1; dr <= 1; dr++)
                for (int dc = -1; dc <= 1; dc++)
                    s += px(r + dr, c + dc) * ((dr == 0 ? 2 : 1) * (dc == 0 ? 2 : 1));
            return (s + 8) / 16;
        end
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                s += px(r + dr, c + dc);
        return (s * 57) / 512;
    endfunction

    task automatic load_frame(input int kind);
        for (int r = 0; r < IMG_H; r++)
            for (int c = 0; c < IMG_W; c++) begin
                case (kind)
                    0: fr[r][c] = int'($urandom_range(0, 255));
                    1: fr[r][c] = ((r % BAND_ROWS) == 0 || (r % BAND_ROWS) == BAND_ROWS - 1) ? 255 : 3;
                    2: fr[r][c] = 255;
                    default: fr[r][c] = (r * 7 + c * 13) % 256;
                endcase
                @(negedge clk);
                ld_en = 1'b1;
                ld_addr = ADDR_W'(r * IMG_W + c);
                ld_data = PIX_W'(fr[r][c]);
            end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_pass(input logic [BANDS-1:0] modes, input bit poke);
        int cyc = 0;
        @(negedge clk);
        mode_i = modes;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        check("R8", int'(busy_o), 1, "busy after start");
        while (!done_o && cyc < PASS_LIMIT + 10) begin
            if (poke && cyc == 40) begin
                start_i = 1'b1;
                mode_i = ~modes;
                ld_en = 1'b1;
                ld_addr = '0;
                ld_data = ~PIX_W'(fr[0][0]);
            end else if (poke && cyc == 41) begin
                start_i = 1'b0;
                ld_en = 1'b0;
                check("R9", int'(busy_o), 1, "busy held over restart");
            end
            @(negedge clk);
            cyc++;
            if (!done_o)
                check("R8", int'(busy_o), 1, "busy during pass");
        end
        check("R8", int'(cyc >= PASS_MIN && cyc <= PASS_LIMIT), 1, "done timing window");
        check("R8", int'(busy_o), 0, "busy low at done");
        @(negedge clk);
        check("R8", int'(done_o), 0, "done one-cycle pulse");
        mode_i = modes;
    endtask

    task automatic compare(input logic [BANDS-1:0] modes, input string tag);
        for (int r = 0; r < IMG_H; r++)
            for (int c = 0; c < IMG_W; c++) begin
                int op = int'(modes[r / BAND_ROWS]);
                int exp = ref_px(r, c, op);
                string req;
                rd_addr = ADDR_W'(r * IMG_W + c);
                #1;
                if (r == 0 || r == IMG_H - 1 || c == 0 || c == IMG_W - 1)
                    req = "R6";
                else if ((r % BAND_ROWS) == 0 || (r % BAND_ROWS) == BAND_ROWS - 1)
                    req = "R5";
                else if (op == 0)
                    req = "R2";
                else
                    req = "R3";
                check(req, int'(rd_data), exp, $sformatf("%s pixel r%0d c%0d", tag, r, c));
            end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        start_i = 1'b0; mode_i = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", int'(busy_o), 0, "busy after reset");
        check("R10", int'(done_o), 0, "done after reset");

        // R1 R2 all bands Gaussian on random data
        load_frame(0);
        run_pass(4'b0000, 1'b0);
        compare(4'b0000, "R1 gauss");

        // R3 R4 mixed modes
        run_pass(4'b1010, 1'b0);
        compare(4'b1010, "R4 mixed");

        // R4 R9 mode change, restart and load during a pass
        run_pass(4'b0101, 1'b1);
        compare(4'b0101, "R4 held");
        run_pass(4'b0101, 1'b0);
        compare(4'b0101, "R9 load ignored");

        // R5 stripes on band seams
        load_frame(1);
        run_pass(4'b0000, 1'b0);
        compare(4'b0000, "R5 seam gauss");
        run_pass(4'b1111, 1'b0);
        compare(4'b1111, "R5 seam box");

        // R6 saturated flat frame and ramp
        load_frame(2);
        run_pass(4'b0110, 1'b0);
        compare(4'b0110, "R6 flat");
        load_frame(3);
        run_pass(4'b1001, 1'b0);
        compare(4'b1001, "R7 ramp");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule